// File: doc/BRIEF.md
# Fetch-Stage Taken-Branch Target Cache with Folding

This block sits beside the program counter in the instruction fetch stage. Every cycle it is looked up combinationally with the current fetch word address. On a hit it returns the address to fetch next, so the redirect is known before decode. Entries also carry the first instruction found at the branch destination. When the stored branch is unconditional, that instruction is handed out in place of the branch. The branch then costs no cycle, and fetch continues at the word after the destination.

Only branches that resolved taken are written. The execute stage reports each resolved branch on the update port. A taken outcome writes or corrects the entry. A not-taken outcome for a branch that is present removes it. The cache is direct-mapped. Low address bits select an entry and the remaining high bits are stored and compared as a tag. Writes take effect at the clock edge, so a lookup in the same cycle as an update sees the contents from before that update.

Top module: `btb_fold`

## Requirements
- R1: After reset every entry is invalid, so any lookup gives lk_hit_o=0, lk_fold_o=0 and lk_fold_instr_o=0.
- R2: On a miss, lk_next_pc_o is lk_pc_i+1 modulo 2^PC_W (the next 4-byte word), lk_fold_o=0 and lk_fold_instr_o=0.
- R3: An update with up_valid_i=1 and up_taken_i=1 writes the entry at the update index. From the next cycle, a lookup of that address hits.
- R4: The entry index is address bits [IDX_W-1:0] (bits [3:0] by default), and the tag is the bits above them. An address with the same index but a different tag misses. A taken update for such an address replaces the resident entry.
- R5: A hit on an entry written with up_uncond_i=0 gives lk_next_pc_o equal to the stored target, with lk_fold_o=0 and lk_fold_instr_o=0.
- R6: A hit on an entry written with up_uncond_i=1 gives lk_fold_o=1, lk_fold_instr_o equal to the stored instruction, and lk_next_pc_o equal to the stored target plus 1.
- R7: An update with up_taken_i=0 invalidates the entry only if that entry is valid and its tag matches the update address. Otherwise nothing changes, and no entry is allocated.
- R8: A taken update that hits an existing entry overwrites its target, instruction and unconditional flag.
- R9: When a lookup and an update address the same index in the same cycle, the lookup returns the contents from before the update.
- R10: While up_valid_i=0, no entry changes, whatever the other update inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_pc_i | input | PC_W | Fetch word address to look up |
| lk_hit_o | output | 1 | A valid entry with a matching tag exists |
| lk_next_pc_o | output | PC_W | Predicted next fetch word address |
| lk_fold_o | output | 1 | Substitute lk_fold_instr_o for the branch |
| lk_fold_instr_o | output | INSTR_W | Destination instruction when folding, else zero |
| up_valid_i | input | 1 | Resolved-branch report present |
| up_pc_i | input | PC_W | Word address of the resolved branch |
| up_taken_i | input | 1 | Branch resolved taken |
| up_uncond_i | input | 1 | Branch is unconditional |
| up_target_i | input | PC_W | Actual destination word address |
| up_instr_i | input | INSTR_W | Instruction at the destination |

## Verification
A wrong valid bit or tag shows up at the very next lookup of the affected address, one clock after the update edge. It appears as a hit where a miss is due, or the reverse, and so as a next address of pc+1 instead of the target. A corrupted target, instruction or unconditional flag shows up in that same cycle as a wrong next address or a wrong fold decision. The fold decision also shifts the next address by one word. A write that lands too early shows up in the same-cycle lookup, before the edge. Aliasing addresses that share one index show whether the tag compare and the replacement behave.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_CLEAR = 2'd2
  } btb_act_e;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int PC_W  = 30,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  assign idx_o = pc_i[IDX_W-1:0];
  assign tag_o = pc_i[PC_W-1:IDX_W];
endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
  import btb_pkg::*;
#(
  parameter int TAG_W = 26
) (
  input  logic             valid_i,
  input  logic             taken_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             res_valid_i,
  input  logic [TAG_W-1:0] res_tag_i,
  output btb_act_e         act_o
);
  logic res_match;
  assign res_match = res_valid_i && (res_tag_i == tag_i);

  always_comb begin
    act_o = ACT_NONE;
    if (valid_i) begin
      if (taken_i)        act_o = ACT_WRITE;
      else if (res_match) act_o = ACT_CLEAR;
    end
  end
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 30,
  parameter int INSTR_W = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  // lookup read
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               rd_valid_o,
  output logic [TAG_W-1:0]   rd_tag_o,
  output logic [PC_W-1:0]    rd_target_o,
  output logic [INSTR_W-1:0] rd_instr_o,
  output logic               rd_uncond_o,
  // update-side residency read
  input  logic [IDX_W-1:0]   chk_idx_i,
  output logic               chk_valid_o,
  output logic [TAG_W-1:0]   chk_tag_o,
  // write
  input  btb_act_e           act_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [PC_W-1:0]    wr_target_i,
  input  logic [INSTR_W-1:0] wr_instr_i,
  input  logic               wr_uncond_i
);
  logic               valid_q  [ENTRIES];
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [PC_W-1:0]    target_q [ENTRIES];
  logic [INSTR_W-1:0] instr_q  [ENTRIES];
  logic               uncond_q [ENTRIES];

  logic [ENTRIES-1:0] wen_vec;
  logic [ENTRIES-1:0] clr_vec;
  logic [ENTRIES-1:0] valid_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign wen_vec[g]   = (act_i == ACT_WRITE) && (wr_idx_i == IDX_W'(g));
    assign clr_vec[g]   = (act_i == ACT_CLEAR) && (wr_idx_i == IDX_W'(g));
    assign valid_vec[g] = valid_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         valid_q[g] <= 1'b0;
      else if (wen_vec[g]) valid_q[g] <= 1'b1;
      else if (clr_vec[g]) valid_q[g] <= 1'b0;
    end

    // payload needs no reset: guarded by valid
    always_ff @(posedge clk_i) begin
      if (wen_vec[g]) begin
        tag_q[g]    <= wr_tag_i;
        target_q[g] <= wr_target_i;
        instr_q[g]  <= wr_instr_i;
        uncond_q[g] <= wr_uncond_i;
      end
    end
  end

  assign rd_valid_o  = valid_q[rd_idx_i];
  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_target_o = target_q[rd_idx_i];
  assign rd_instr_o  = instr_q[rd_idx_i];
  assign rd_uncond_o = uncond_q[rd_idx_i];
  assign chk_valid_o = valid_q[chk_idx_i];
  assign chk_tag_o   = tag_q[chk_idx_i];

  // R4: direct mapped, one entry touched per cycle
  a_r4_single_entry_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wen_vec | clr_vec));

  // R3: a write leaves the entry valid
  a_r3_write_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_WRITE) |=> valid_vec[$past(wr_idx_i)]);

  // R7: a clear drops the entry
  a_r7_clear_drops_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_CLEAR) |=> !valid_vec[$past(wr_idx_i)]);

  // R10: no action, no change
  a_r10_idle_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_NONE) |=> $stable(valid_vec));
endmodule

// File: rtl/btb_fold.sv
module btb_fold
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 30,
  parameter int INSTR_W = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PC_W-1:0]    lk_pc_i,
  output logic               lk_hit_o,
  output logic [PC_W-1:0]    lk_next_pc_o,
  output logic               lk_fold_o,
  output logic [INSTR_W-1:0] lk_fold_instr_o,
  input  logic               up_valid_i,
  input  logic [PC_W-1:0]    up_pc_i,
  input  logic               up_taken_i,
  input  logic               up_uncond_i,
  input  logic [PC_W-1:0]    up_target_i,
  input  logic [INSTR_W-1:0] up_instr_i
);
  logic [IDX_W-1:0]   lk_idx, up_idx;
  logic [TAG_W-1:0]   lk_tag, up_tag;
  logic               rd_valid, rd_uncond, chk_valid;
  logic [TAG_W-1:0]   rd_tag, chk_tag;
  logic [PC_W-1:0]    rd_target;
  logic [INSTR_W-1:0] rd_instr;
  btb_act_e           act;

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_split (
    .pc_i(lk_pc_i), .idx_o(lk_idx), .tag_o(lk_tag));

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_split (
    .pc_i(up_pc_i), .idx_o(up_idx), .tag_o(up_tag));

  btb_update_ctl #(.TAG_W(TAG_W)) u_ctl (
    .valid_i     (up_valid_i),
    .taken_i     (up_taken_i),
    .tag_i       (up_tag),
    .res_valid_i (chk_valid),
    .res_tag_i   (chk_tag),
    .act_o       (act)
  );

  btb_store #(.ENTRIES(ENTRIES), .PC_W(PC_W), .INSTR_W(INSTR_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (lk_idx),
    .rd_valid_o  (rd_valid),
    .rd_tag_o    (rd_tag),
    .rd_target_o (rd_target),
    .rd_instr_o  (rd_instr),
    .rd_uncond_o (rd_uncond),
    .chk_idx_i   (up_idx),
    .chk_valid_o (chk_valid),
    .chk_tag_o   (chk_tag),
    .act_i       (act),
    .wr_idx_i    (up_idx),
    .wr_tag_i    (up_tag),
    .wr_target_i (up_target_i),
    .wr_instr_i  (up_instr_i),
    .wr_uncond_i (up_uncond_i)
  );

  logic hit, fold;
  assign hit  = rd_valid && (rd_tag == lk_tag);
  assign fold = hit && rd_uncond;

  always_comb begin
    lk_hit_o        = hit;
    lk_fold_o       = fold;
    lk_fold_instr_o = fold ? rd_instr : '0;
    if (fold)     lk_next_pc_o = rd_target + PC_W'(1); // target already issued
    else if (hit) lk_next_pc_o = rd_target;
    else          lk_next_pc_o = lk_pc_i + PC_W'(1);
  end

  // R3: a taken report is visible to a lookup of the same PC next cycle
  a_r3_hit_after_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(up_valid_i && up_taken_i) && (lk_pc_i == $past(up_pc_i)))
      |-> (lk_hit_o && (lk_fold_o == $past(up_uncond_i))));

  // R7: a not-taken report leaves that PC absent next cycle
  a_r7_miss_after_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(up_valid_i && !up_taken_i) && (lk_pc_i == $past(up_pc_i))) |-> !lk_hit_o);

  // R6: folding only on a hit
  a_r6_fold_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fold_o |-> lk_hit_o);

  // R2: no instruction leaks out without folding
  a_r2_no_instr_without_fold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_fold_o |-> (lk_fold_instr_o == '0));
endmodule

// File: tb/tb_btb_fold.sv
module tb_btb_fold;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W    = 30;
  localparam int INSTR_W = 32;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [PC_W-1:0]    lk_pc_i = '0;
  logic               lk_hit_o;
  logic [PC_W-1:0]    lk_next_pc_o;
  logic               lk_fold_o;
  logic [INSTR_W-1:0] lk_fold_instr_o;
  logic               up_valid_i = 1'b0;
  logic [PC_W-1:0]    up_pc_i = '0;
  logic               up_taken_i = 1'b0;
  logic               up_uncond_i = 1'b0;
  logic [PC_W-1:0]    up_target_i = '0;
  logic [INSTR_W-1:0] up_instr_i = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  btb_fold dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc);
    @(negedge clk_i);
    lk_pc_i = pc;
    #1;
  endtask

  task automatic expect_lk(input string req, input logic hit, input logic [PC_W-1:0] nxt,
                           input logic fold, input logic [INSTR_W-1:0] ins);
    chk({req, " hit"}, 64'(lk_hit_o), 64'(hit));
    chk({req, " next"}, 64'(lk_next_pc_o), 64'(nxt));
    chk({req, " fold"}, 64'(lk_fold_o), 64'(fold));
    chk({req, " instr"}, 64'(lk_fold_instr_o), 64'(ins));
  endtask

  task automatic upd(input logic vld, input logic [PC_W-1:0] pc, input logic tk,
                     input logic unc, input logic [PC_W-1:0] tgt, input logic [INSTR_W-1:0] ins);
    @(negedge clk_i);
    up_valid_i = vld; up_pc_i = pc; up_taken_i = tk;
    up_uncond_i = unc; up_target_i = tgt; up_instr_i = ins;
    @(posedge clk_i);
    #1 up_valid_i = 1'b0;
  endtask

  localparam logic [PC_W-1:0] PC_A = 30'h0001_2345; // idx 5
  localparam logic [PC_W-1:0] PC_B = 30'h0002_2345; // idx 5, other tag
  localparam logic [PC_W-1:0] PC_C = 30'h0000_00A7; // idx 7
  localparam logic [PC_W-1:0] PC_D = 30'h0000_00B3; // idx 3

  task automatic t_reset;
    look(30'h0000_0123);
    expect_lk("R1 after reset", 1'b0, 30'h0000_0124, 1'b0, '0);
    look(30'h3FFF_FFFF);
    expect_lk("R2 wrap", 1'b0, 30'h0, 1'b0, '0);
  endtask

  task automatic t_alloc_cond;
    upd(1'b1, PC_A, 1'b1, 1'b0, 30'h0000_0800, 32'hDEAD_0001);
    look(PC_A);
    expect_lk("R3 R5 conditional hit", 1'b1, 30'h0000_0800, 1'b0, '0);
  endtask

  task automatic t_alias;
    look(PC_B);
    expect_lk("R4 alias miss", 1'b0, PC_B + 30'd1, 1'b0, '0);
    upd(1'b1, PC_B, 1'b1, 1'b1, 30'h0000_0900, 32'hCAFE_0002);
    look(PC_A);
    expect_lk("R4 replaced", 1'b0, PC_A + 30'd1, 1'b0, '0);
    look(PC_B);
    expect_lk("R6 fold hit", 1'b1, 30'h0000_0901, 1'b1, 32'hCAFE_0002);
  endtask

  task automatic t_invalidate;
    upd(1'b1, PC_A, 1'b0, 1'b0, 30'h0, 32'h0);
    look(PC_B);
    expect_lk("R7 tag mismatch keeps", 1'b1, 30'h0000_0901, 1'b1, 32'hCAFE_0002);
    upd(1'b1, PC_B, 1'b0, 1'b0, 30'h0, 32'h0);
    look(PC_B);
    expect_lk("R7 invalidated", 1'b0, PC_B + 30'd1, 1'b0, '0);
    upd(1'b1, PC_D, 1'b0, 1'b1, 30'h0000_0555, 32'h5555_5555);
    look(PC_D);
    expect_lk("R7 no alloc", 1'b0, PC_D + 30'd1, 1'b0, '0);
  endtask

  task automatic t_correct;
    upd(1'b1, PC_C, 1'b1, 1'b0, 30'h0000_0100, 32'h0000_0AAA);
    look(PC_C);
    expect_lk("R8 before", 1'b1, 30'h0000_0100, 1'b0, '0);
    upd(1'b1, PC_C, 1'b1, 1'b1, 30'h0000_0200, 32'h1111_2222);
    look(PC_C);
    expect_lk("R8 corrected", 1'b1, 30'h0000_0201, 1'b1, 32'h1111_2222);
  endtask

  task automatic t_same_cycle;
    @(negedge clk_i);
    lk_pc_i = PC_C;
    up_valid_i = 1'b1; up_pc_i = PC_C; up_taken_i = 1'b0;
    up_uncond_i = 1'b0; up_target_i = '0; up_instr_i = '0;
    #1;
    expect_lk("R9 old contents", 1'b1, 30'h0000_0201, 1'b1, 32'h1111_2222);
    @(posedge clk_i);
    #1 up_valid_i = 1'b0;
    #1;
    expect_lk("R9 after edge", 1'b0, PC_C + 30'd1, 1'b0, '0);
  endtask

  task automatic t_idle_update;
    upd(1'b0, PC_D, 1'b1, 1'b1, 30'h0000_0777, 32'h7777_7777);
    look(PC_D);
    expect_lk("R10 ignored write", 1'b0, PC_D + 30'd1, 1'b0, '0);
    upd(1'b1, PC_D, 1'b1, 1'b0, 30'h0000_0333, 32'h3);
    upd(1'b0, PC_D, 1'b0, 1'b0, 30'h0, 32'h0);
    look(PC_D);
    expect_lk("R10 ignored clear", 1'b1, 30'h0000_0333, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_alloc_cond();
    t_alias();
    t_invalidate();
    t_correct();
    t_same_cycle();
    t_idle_update();
    repeat (2) @(posedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule